// File: doc/BRIEF.md
# Channel-Filtered Debug Event Unit

This unit watches an event-driven, multi-channel timing coprocessor and decides when to stop it, when to report a watchpoint and when to switch trace on or off. Two address comparators look at the instruction fetch bus or at the data bus. A data comparator can also require a matching data value. Five special service strobes can each be routed to halt the core or to report a watchpoint. Every comparator and special-event hit is qualified by the number of the channel being serviced, through a value/mask pair.

A client-breakpoint input from the master core and a twin-engine breakpoint input from a partner engine can also request a halt. A timing select decides where that halt lands: at the end of the current microcycle, or only once the service thread has completed and the core is idle. The halt request is held until the core acknowledges entry to debug state. A sticky status register records which sources fired, and software clears it by writing ones.

The unit is set up through a simple word-addressed register port. Reads are combinational on the address.

Top module: `dbg_event_unit`

## Requirements
- R1: After reset, halt_req_o, watch_o, trace_en_o and cfg_err_o are 0 and the status register (address 8) reads 0.
- R2: A comparator whose config word (address 2+3k for comparator k) has bit0=1 (enable) and bit1=0 (instruction kind) hits when fetch_valid_i is high and fetch_addr_i equals its address word (address 3+3k).
- R3: With config bit1=1 (data kind), a comparator hits on dacc_valid_i with dacc_addr_i equal to its address word. When config bit2=1, dacc_data_i must also equal its data word (address 4+3k), and otherwise there is no hit.
- R4: Comparator and special-event hits count only when ((chan_i ^ value) & mask) == 0. The value is control register (address 0) bits [4:0] and the mask is bits [12:8]. Mask 0 accepts every channel.
- R5: Comparator action field config[5:4]: 0 halts; 1 gives watch_o high for exactly one cycle, the cycle after the hit, with watch_id_o = k; 2 sets trace_en_o; 3 clears trace_en_o.
- R6: Special strobes sev_i bit0..bit4 are channel-register write, host service, link service, match recognition and transition detect. Route register (address 1) bits [4:0] send each to halt (status bit2), and bits [12:8] send each to watch with watch_id_o = 2 + bit index. A strobe that is routed to neither has no effect.
- R7: When a special event is enabled for both halt and watch, cfg_err_o is 1, and that event causes neither a halt nor a watch pulse.
- R8: halt_req_o rises the cycle after a halt source fires and stays high until dbg_ack_i is seen, then falls the next cycle. Status bits (0: comparator 0, 1: comparator 1, 2: special event, 3: client, 4: twin) stay set until a 1 is written to them at address 8.
- R9: Client and twin inputs are halt sources only when enabled by control bits 16 (client) and 17 (twin). When disabled they are ignored.
- R10: Control bit 18 = 0 makes a client or twin request halt at the next uc_end_i pulse. Bit 18 = 1 makes it wait until idle_i is high.
- R11: When several watch sources hit in the same cycle, watch_id_o reports the lowest identifier.
- R12: When both comparators hit with trace actions in the same cycle, comparator 0's action decides trace_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i |
| fetch_valid_i | input | 1 | Instruction fetch valid |
| fetch_addr_i | input | 16 | Instruction fetch address |
| dacc_valid_i | input | 1 | Data access valid |
| dacc_addr_i | input | 16 | Data access address |
| dacc_data_i | input | 32 | Data access value |
| chan_i | input | 5 | Channel currently being serviced |
| sev_i | input | 5 | Special service event strobes |
| clt_brk_i | input | 1 | Client breakpoint request from master core |
| twin_brk_i | input | 1 | Breakpoint request from partner engine |
| uc_end_i | input | 1 | End of current microcycle |
| idle_i | input | 1 | Core idle, no thread running |
| dbg_ack_i | input | 1 | Core has entered debug state |
| halt_req_o | output | 1 | Halt request to the core sequencer |
| watch_o | output | 1 | Watchpoint-hit pulse |
| watch_id_o | output | 3 | Source of the watchpoint hit |
| trace_en_o | output | 1 | Trace generation enable |
| cfg_err_o | output | 1 | Illegal halt-and-watch routing on a special event |

## Verification
The assertions assume that every input is a settled, known level at each rising edge. They also assume that strobes such as sev_i, uc_end_i and the breakpoint inputs are plain levels sampled once per cycle, with no meaning attached to their edges. The stimulus changes inputs only on the falling clock edge, holds each strobe for exactly one cycle, and raises dbg_ack_i only after a halt request has been observed. Status bits are cleared by software only after the acknowledge, so the held-request and source-recording properties are exercised the way the core would use them.

// File: rtl/dbg_event_pkg.sv
package dbg_event_pkg;
  typedef enum logic [1:0] {
    ACT_HALT    = 2'd0,
    ACT_WATCH   = 2'd1,
    ACT_TRC_ON  = 2'd2,
    ACT_TRC_OFF = 2'd3
  } act_e;

  localparam int NUM_SEV = 5;
  // control register field offsets
  localparam int CTL_MASK_LSB = 8;
  localparam int CTL_CLT_EN   = 16;
  localparam int CTL_TWIN_EN  = 17;
  localparam int CTL_TSEL     = 18;
  localparam int RTE_WCH_LSB  = 8;
endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp #(
  parameter int PA_W = 16,
  parameter int DA_W = 16,
  parameter int DW   = 32
) (
  input  logic            en_i,
  input  logic            is_data_i,
  input  logic            dcmp_i,
  input  logic [PA_W-1:0] ref_pa_i,
  input  logic [DA_W-1:0] ref_da_i,
  input  logic [DW-1:0]   ref_data_i,
  input  logic            chan_ok_i,
  input  logic            fetch_valid_i,
  input  logic [PA_W-1:0] fetch_addr_i,
  input  logic            dacc_valid_i,
  input  logic [DA_W-1:0] dacc_addr_i,
  input  logic [DW-1:0]   dacc_data_i,
  output logic            hit_o
);
  logic ins_hit, dat_hit;

  assign ins_hit = fetch_valid_i && (fetch_addr_i == ref_pa_i);
  assign dat_hit = dacc_valid_i && (dacc_addr_i == ref_da_i) &&
                   (!dcmp_i || (dacc_data_i == ref_data_i));
  assign hit_o   = en_i && chan_ok_i && (is_data_i ? dat_hit : ins_hit);
endmodule

// File: rtl/dbg_watch_enc.sv
module dbg_watch_enc #(
  parameter int N    = 7,
  parameter int ID_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    hit_i,
  output logic            watch_o,
  output logic [ID_W-1:0] id_o
);
  logic [ID_W-1:0] id_d;

  // lowest index wins
  always_comb begin
    id_d = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) id_d = ID_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      watch_o <= 1'b0;
      id_o    <= '0;
    end else begin
      watch_o <= |hit_i;
      id_o    <= id_d;
    end
  end

  p_watch_one_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    watch_o |-> $past(|hit_i));
endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl #(
  parameter int N_IMM = 3,
  localparam int N_SRC = N_IMM + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IMM-1:0] imm_i,
  input  logic             clt_i,
  input  logic             twin_i,
  input  logic             clt_en_i,
  input  logic             twin_en_i,
  input  logic             tsel_i,
  input  logic             uc_end_i,
  input  logic             idle_i,
  input  logic             ack_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic             halt_req_o,
  output logic [N_SRC-1:0] status_o
);
  logic clt_pend_q, twin_pend_q;
  logic clt_req, twin_req, release_pt, clt_fire, twin_fire;
  logic [N_SRC-1:0] fire;

  assign release_pt = tsel_i ? idle_i : uc_end_i;
  assign clt_req    = clt_pend_q  || (clt_i  && clt_en_i);
  assign twin_req   = twin_pend_q || (twin_i && twin_en_i);
  assign clt_fire   = clt_req  && release_pt;
  assign twin_fire  = twin_req && release_pt;
  assign fire       = {twin_fire, clt_fire, imm_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clt_pend_q  <= 1'b0;
      twin_pend_q <= 1'b0;
      status_o    <= '0;
      halt_req_o  <= 1'b0;
    end else begin
      clt_pend_q  <= clt_req  && !release_pt;
      twin_pend_q <= twin_req && !release_pt;
      status_o    <= (status_o & ~clr_i) | fire;
      if (ack_i)      halt_req_o <= 1'b0;
      else if (|fire) halt_req_o <= 1'b1;
    end
  end

  p_halt_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_req_o && !ack_i) |=> halt_req_o);

  p_ack_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !halt_req_o);

  p_clt_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[N_IMM]) |-> $past(tsel_i ? idle_i : uc_end_i));

  p_twin_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[N_IMM+1]) |-> $past(tsel_i ? idle_i : uc_end_i));
endmodule

// File: rtl/dbg_event_unit.sv
module dbg_event_unit
  import dbg_event_pkg::*;
#(
  parameter int N_CMP = 2,
  parameter int PA_W  = 16,
  parameter int DA_W  = 16,
  parameter int DW    = 32,
  parameter int CH_W  = 5,
  localparam int N_REG = 3 + 3 * N_CMP,
  localparam int AW    = $clog2(N_REG),
  localparam int N_WID = N_CMP + NUM_SEV,
  localparam int ID_W  = $clog2(N_WID)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [AW-1:0]   cfg_addr_i,
  input  logic [DW-1:0]   cfg_wdata_i,
  output logic [DW-1:0]   cfg_rdata_o,
  input  logic            fetch_valid_i,
  input  logic [PA_W-1:0] fetch_addr_i,
  input  logic            dacc_valid_i,
  input  logic [DA_W-1:0] dacc_addr_i,
  input  logic [DW-1:0]   dacc_data_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic [NUM_SEV-1:0] sev_i,
  input  logic            clt_brk_i,
  input  logic            twin_brk_i,
  input  logic            uc_end_i,
  input  logic            idle_i,
  input  logic            dbg_ack_i,
  output logic            halt_req_o,
  output logic            watch_o,
  output logic [ID_W-1:0] watch_id_o,
  output logic            trace_en_o,
  output logic            cfg_err_o
);
  localparam int N_SRC    = N_CMP + 3;
  localparam int REG_CTL  = 0;
  localparam int REG_RTE  = 1;
  localparam int REG_STAT = 2 + 3 * N_CMP;

  logic [DW-1:0] ctl_q, rte_q;
  logic [DW-1:0] cmp_cfg_q [N_CMP];
  logic [DW-1:0] cmp_adr_q [N_CMP];
  logic [DW-1:0] cmp_dat_q [N_CMP];
  logic [N_SRC-1:0] status, stat_clr;

  logic chan_ok;
  logic [N_CMP-1:0] cmp_hit, cmp_halt, cmp_watch;
  logic [NUM_SEV-1:0] sev_brk_en, sev_wch_en, sev_ok, sev_brk, sev_wch;
  logic trace_d;

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      rte_q <= '0;
      for (int k = 0; k < N_CMP; k++) begin
        cmp_cfg_q[k] <= '0;
        cmp_adr_q[k] <= '0;
        cmp_dat_q[k] <= '0;
      end
    end else if (cfg_we_i) begin
      if (cfg_addr_i == AW'(REG_CTL)) ctl_q <= cfg_wdata_i;
      if (cfg_addr_i == AW'(REG_RTE)) rte_q <= cfg_wdata_i;
      for (int k = 0; k < N_CMP; k++) begin
        if (cfg_addr_i == AW'(2 + 3 * k)) cmp_cfg_q[k] <= cfg_wdata_i;
        if (cfg_addr_i == AW'(3 + 3 * k)) cmp_adr_q[k] <= cfg_wdata_i;
        if (cfg_addr_i == AW'(4 + 3 * k)) cmp_dat_q[k] <= cfg_wdata_i;
      end
    end
  end

  assign stat_clr = (cfg_we_i && cfg_addr_i == AW'(REG_STAT)) ?
                    cfg_wdata_i[N_SRC-1:0] : '0;

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == AW'(REG_CTL))  cfg_rdata_o = ctl_q;
    if (cfg_addr_i == AW'(REG_RTE))  cfg_rdata_o = rte_q;
    if (cfg_addr_i == AW'(REG_STAT)) cfg_rdata_o = DW'(status);
    for (int k = 0; k < N_CMP; k++) begin
      if (cfg_addr_i == AW'(2 + 3 * k)) cfg_rdata_o = cmp_cfg_q[k];
      if (cfg_addr_i == AW'(3 + 3 * k)) cfg_rdata_o = cmp_adr_q[k];
      if (cfg_addr_i == AW'(4 + 3 * k)) cfg_rdata_o = cmp_dat_q[k];
    end
  end

  // ---------------- channel qualifier ----------------
  assign chan_ok = ((chan_i ^ ctl_q[CH_W-1:0]) & ctl_q[CTL_MASK_LSB +: CH_W]) == '0;

  // ---------------- comparators ----------------
  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    act_e act;
    assign act = act_e'(cmp_cfg_q[k][5:4]);

    dbg_cmp #(.PA_W(PA_W), .DA_W(DA_W), .DW(DW)) u_cmp (
      .en_i         (cmp_cfg_q[k][0]),
      .is_data_i    (cmp_cfg_q[k][1]),
      .dcmp_i       (cmp_cfg_q[k][2]),
      .ref_pa_i     (cmp_adr_q[k][PA_W-1:0]),
      .ref_da_i     (cmp_adr_q[k][DA_W-1:0]),
      .ref_data_i   (cmp_dat_q[k]),
      .chan_ok_i    (chan_ok),
      .fetch_valid_i(fetch_valid_i),
      .fetch_addr_i (fetch_addr_i),
      .dacc_valid_i (dacc_valid_i),
      .dacc_addr_i  (dacc_addr_i),
      .dacc_data_i  (dacc_data_i),
      .hit_o        (cmp_hit[k])
    );

    assign cmp_halt[k]  = cmp_hit[k] && (act == ACT_HALT);
    assign cmp_watch[k] = cmp_hit[k] && (act == ACT_WATCH);
  end

  // ---------------- special events ----------------
  assign sev_brk_en = rte_q[NUM_SEV-1:0];
  assign sev_wch_en = rte_q[RTE_WCH_LSB +: NUM_SEV];
  assign cfg_err_o  = |(sev_brk_en & sev_wch_en);
  assign sev_ok     = chan_ok ? sev_i : '0;
  assign sev_brk    = sev_ok & sev_brk_en & ~sev_wch_en;
  assign sev_wch    = sev_ok & sev_wch_en & ~sev_brk_en;

  // ---------------- trace enable (comparator 0 decides last) ----------------
  always_comb begin
    trace_d = trace_en_o;
    for (int k = N_CMP - 1; k >= 0; k--) begin
      if (cmp_hit[k] && act_e'(cmp_cfg_q[k][5:4]) == ACT_TRC_ON)  trace_d = 1'b1;
      if (cmp_hit[k] && act_e'(cmp_cfg_q[k][5:4]) == ACT_TRC_OFF) trace_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trace_en_o <= 1'b0;
    else         trace_en_o <= trace_d;
  end

  // ---------------- watch and halt ----------------
  dbg_watch_enc #(.N(N_WID), .ID_W(ID_W)) u_watch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  ({sev_wch, cmp_watch}),
    .watch_o(watch_o),
    .id_o   (watch_id_o)
  );

  dbg_halt_ctl #(.N_IMM(N_CMP + 1)) u_halt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .imm_i     ({|sev_brk, cmp_halt}),
    .clt_i     (clt_brk_i),
    .twin_i    (twin_brk_i),
    .clt_en_i  (ctl_q[CTL_CLT_EN]),
    .twin_en_i (ctl_q[CTL_TWIN_EN]),
    .tsel_i    (ctl_q[CTL_TSEL]),
    .uc_end_i  (uc_end_i),
    .idle_i    (idle_i),
    .ack_i     (dbg_ack_i),
    .clr_i     (stat_clr),
    .halt_req_o(halt_req_o),
    .status_o  (status)
  );

  p_watch_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    watch_o |-> $past(fetch_valid_i || dacc_valid_i || (|sev_i)));

  p_trace_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trace_en_o) |-> $past(fetch_valid_i || dacc_valid_i));

  p_watch_id_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    watch_o |-> (watch_id_o < ID_W'(N_WID)));

  p_conflict_no_halt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_err_o) && $past(sev_i == (sev_brk_en & sev_wch_en)) && $past(sev_i != '0)
     && $past(!fetch_valid_i && !dacc_valid_i && !clt_brk_i && !twin_brk_i && !uc_end_i && !idle_i)
     && $past(!halt_req_o) && $past(!dbg_ack_i)) |-> !watch_o);
endmodule

// File: tb/dbg_event_unit_tb.sv
module dbg_event_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        dacc_valid = 1'b0;
  logic [15:0] dacc_addr = '0;
  logic [31:0] dacc_data = '0;
  logic [4:0]  chan = '0;
  logic [4:0]  sev = '0;
  logic        clt = 1'b0, twin = 1'b0, uc_end = 1'b0, idle = 1'b0, ack = 1'b0;
  logic        halt_req, watch, trace_en, cfg_err;
  logic [2:0]  watch_id;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dbg_event_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
    .dacc_valid_i(dacc_valid), .dacc_addr_i(dacc_addr), .dacc_data_i(dacc_data),
    .chan_i(chan), .sev_i(sev), .clt_brk_i(clt), .twin_brk_i(twin),
    .uc_end_i(uc_end), .idle_i(idle), .dbg_ack_i(ack),
    .halt_req_o(halt_req), .watch_o(watch), .watch_id_o(watch_id),
    .trace_en_o(trace_en), .cfg_err_o(cfg_err)
  );

  localparam logic [31:0] CLT_EN = 32'h1 << 16;
  localparam logic [31:0] TW_EN  = 32'h1 << 17;
  localparam logic [31:0] TSEL   = 32'h1 << 18;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic do_fetch(input logic [15:0] a, input logic [4:0] ch);
    @(negedge clk); fetch_valid = 1'b1; fetch_addr = a; chan = ch;
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  task automatic do_dacc(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); dacc_valid = 1'b1; dacc_addr = a; dacc_data = d;
    @(negedge clk); dacc_valid = 1'b0;
  endtask

  task automatic do_sev(input logic [4:0] v);
    @(negedge clk); sev = v;
    @(negedge clk); sev = '0;
  endtask

  task automatic ack_and_clear(input string tag, input logic [31:0] bits);
    logic [31:0] d;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk({tag, " halt drops after ack"}, halt_req, 0);
    rd(4'd8, d);
    chk({tag, " status kept after ack"}, d, bits);
    wr(4'd8, bits);
    rd(4'd8, d);
    chk({tag, " status cleared by W1C"}, d, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 halt", halt_req, 0);
    chk("R1 watch", watch, 0);
    chk("R1 trace", trace_en, 0);
    chk("R1 err", cfg_err, 0);
    rd(4'd8, d);
    chk("R1 status", d, 0);
  endtask

  task automatic t_instr;
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h120);
    wr(4'd2, 32'h11);              // en, instr, watch
    do_fetch(16'h120, 5'd3);
    chk("R2 watch on fetch hit", watch, 1);
    chk("R5 watch id cmp0", watch_id, 0);
    @(negedge clk);
    chk("R5 watch single cycle", watch, 0);
    do_fetch(16'h121, 5'd3);
    chk("R2 no watch on other addr", watch, 0);
  endtask

  task automatic t_data;
    logic [31:0] d;
    wr(4'd6, 32'h40);
    wr(4'd7, 32'hCAFE);
    wr(4'd5, 32'h07);              // en, data, dcmp, halt
    do_dacc(16'h40, 32'hBEEF);
    chk("R3 no halt on data mismatch", halt_req, 0);
    do_dacc(16'h40, 32'hCAFE);
    chk("R3 halt on data match", halt_req, 1);
    rd(4'd8, d);
    chk("R8 status cmp1", d, 32'h2);
    repeat (3) @(negedge clk);
    chk("R8 halt held without ack", halt_req, 1);
    ack_and_clear("R8", 32'h2);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_chan;
    wr(4'd0, 32'h5 | (32'h1F << 8));
    do_fetch(16'h120, 5'd6);
    chk("R4 exact filter rejects ch6", watch, 0);
    do_fetch(16'h120, 5'd5);
    chk("R4 exact filter accepts ch5", watch, 1);
    wr(4'd0, 32'h4 | (32'h1C << 8));
    do_fetch(16'h120, 5'd6);
    chk("R4 masked filter accepts ch6", watch, 1);
    do_fetch(16'h120, 5'd9);
    chk("R4 masked filter rejects ch9", watch, 0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_trace;
    wr(4'd2, 32'h21);
    do_fetch(16'h120, 5'd0);
    chk("R5 trace on", trace_en, 1);
    wr(4'd2, 32'h31);
    do_fetch(16'h120, 5'd0);
    chk("R5 trace off", trace_en, 0);
    wr(4'd2, 32'h21);
    wr(4'd6, 32'h120);
    wr(4'd5, 32'h31);              // cmp1 instr, trace off
    do_fetch(16'h120, 5'd0);
    chk("R12 cmp0 wins trace", trace_en, 1);
    wr(4'd5, 32'h0);
  endtask

  task automatic t_sev;
    logic [31:0] d;
    wr(4'd2, 32'h0);
    wr(4'd1, 32'h02 | (32'h08 << 8));
    do_sev(5'b01000);
    chk("R6 match event watch", watch, 1);
    chk("R6 match event id", watch_id, 5);
    do_sev(5'b00010);
    chk("R6 host event halt", halt_req, 1);
    rd(4'd8, d);
    chk("R6 status special", d, 32'h4);
    ack_and_clear("R6", 32'h4);
    do_sev(5'b00001);
    chk("R6 unrouted no watch", watch, 0);
    chk("R6 unrouted no halt", halt_req, 0);
    wr(4'd2, 32'h11);
    @(negedge clk); fetch_valid = 1'b1; fetch_addr = 16'h120; sev = 5'b01000;
    @(negedge clk); fetch_valid = 1'b0; sev = '0;
    chk("R11 watch on simultaneous", watch, 1);
    chk("R11 lowest id wins", watch_id, 0);
    wr(4'd2, 32'h0);
  endtask

  task automatic t_conflict;
    logic [31:0] d;
    wr(4'd1, 32'h04 | (32'h04 << 8));
    chk("R7 error flag", cfg_err, 1);
    do_sev(5'b00100);
    chk("R7 no watch on conflict", watch, 0);
    chk("R7 no halt on conflict", halt_req, 0);
    rd(4'd8, d);
    chk("R7 status untouched", d, 0);
    wr(4'd1, 32'h0);
    chk("R7 error clears", cfg_err, 0);
  endtask

  task automatic t_client;
    logic [31:0] d;
    wr(4'd0, CLT_EN);
    @(negedge clk); clt = 1'b1;
    @(negedge clk); clt = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 client waits for microcycle end", halt_req, 0);
    @(negedge clk); uc_end = 1'b1;
    @(negedge clk); uc_end = 1'b0;
    chk("R10 client halts at microcycle end", halt_req, 1);
    rd(4'd8, d);
    chk("R9 status client", d, 32'h8);
    ack_and_clear("R9", 32'h8);
    wr(4'd0, 32'h0);
    @(negedge clk); twin = 1'b1; clt = 1'b1; uc_end = 1'b1;
    @(negedge clk); twin = 1'b0; clt = 1'b0; uc_end = 1'b0;
    chk("R9 disabled inputs ignored", halt_req, 0);
    rd(4'd8, d);
    chk("R9 disabled status clear", d, 0);
  endtask

  task automatic t_thread;
    logic [31:0] d;
    wr(4'd0, TW_EN | TSEL);
    @(negedge clk); twin = 1'b1;
    @(negedge clk); twin = 1'b0; uc_end = 1'b1;
    @(negedge clk); uc_end = 1'b0;
    chk("R10 thread mode ignores microcycle end", halt_req, 0);
    @(negedge clk); idle = 1'b1;
    @(negedge clk); idle = 1'b0;
    chk("R10 thread mode halts at idle", halt_req, 1);
    rd(4'd8, d);
    chk("R9 status twin", d, 32'h10);
    ack_and_clear("R10", 32'h10);
    wr(4'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_instr();
    t_data();
    t_chan();
    t_trace();
    t_sev();
    t_conflict();
    t_client();
    t_thread();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule